// File: doc/BRIEF.md
# Serial Stepped-Attenuator Control Register

This block is the digital front end of a single-channel stepped audio attenuator. A host drives three serial lines: an active-low frame enable, a serial clock and a serial data bit. While the enable is low, each rising edge of the serial clock shifts one data bit into a frame register. When the enable returns high, the frame is checked and decoded into the switch controls of the analog ladder.

The block runs on a fast system clock. Every serial line passes through a two-flop synchronizer, and edges of the serial clock and of the enable are found in the system clock domain. A frame carries a channel address byte and a level byte. Level codes 0 to 62 select one ladder tap, which gives attenuation equal to the code in 1 dB steps. Any higher code selects mute, where no tap is closed and the output-ground switch is enabled. The block wakes up in mute.

Top module: `serial_atten_ctrl`

## Requirements
- R1: After reset the block is in mute: `muted` = 1, `gndEn` = 1, `tapSel` all zero, `level` = 63.
- R2: A data bit is captured only on a rising edge of `serClk` while `serLoadN` is low. Serial clock edges while `serLoadN` is high capture nothing.
- R3: A frame is 16 bits sent most significant bit first. The first 8 bits received are the address byte and the last 8 bits are the level byte.
- R4: A shifted frame has no effect on the outputs until `serLoadN` rises. The new setting appears a few system cycles after that rise.
- R5: A frame whose address byte is not 0x00 leaves all outputs unchanged.
- R6: A level code c from 0 to 62 drives `tapSel` with only bit c set, `level` = c, `muted` = 0 and `gndEn` = 0.
- R7: Any level code from 63 to 255 selects mute: `tapSel` all zero, `muted` = 1, `gndEn` = 1, `level` = 63.
- R8: If the number of bits shifted while `serLoadN` was low is not exactly 16 when `serLoadN` rises, the frame is discarded and the outputs are unchanged.
- R9: At no time is more than one bit of `tapSel` set, and `gndEn` is never high while any tap is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serLoadN | input | 1 | Serial frame enable, active low, asynchronous to clk |
| serClk | input | 1 | Serial shift clock, asynchronous to clk |
| serData | input | 1 | Serial data bit, asynchronous to clk |
| tapSel | output | 63 | One-hot ladder tap select, bit c for c dB |
| muted | output | 1 | High when the channel is muted |
| gndEn | output | 1 | Enables the output-grounding switch, high in mute |
| level | output | 6 | Applied level code, 63 while muted |

## Verification
Any error in the committed setting register shows at the ports within about four system cycles after the enable rises, as a wrong tap bit, a wrong `level` or a wrong mute pair. A wrong bit counter or a shift error stays hidden in the frame register until the next enable rise. It then shows as a frame that is taken or dropped by mistake, so the bench follows every frame with a full compare of the outputs. The sweep covers all 256 level codes, so a decode slip at the 62/63 boundary or in the upper code range shows as a mismatch on that exact frame.

// File: rtl/atten_pkg.sv
package atten_pkg;

  // Strobes from the control section to the datapath, one system cycle wide
  typedef struct packed {
    logic shift;   // capture bitVal into the frame register
    logic commit;  // a complete frame is present, apply it if addressed
    logic bitVal;  // synchronized serial data bit
  } atten_strobe_t;

endpackage

// File: rtl/atten_ctl.sv
module atten_ctl
  import atten_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_W     = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serLoadN,
  input  logic          serClk,
  input  logic          serData,
  output atten_strobe_t stb
);

  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] OVER_CNT = CNT_W'(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] loadPipe, clkPipe, dataPipe;
  logic loadS, clkS, dataS;
  logic prevLoad, prevClk;
  logic clkRise, loadRise;
  logic [CNT_W-1:0] bitCnt;

  // Synchronizers; the frame enable idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadPipe <= '1;
      clkPipe  <= '0;
      dataPipe <= '0;
    end else begin
      loadPipe <= {loadPipe[SYNC_STAGES-2:0], serLoadN};
      clkPipe  <= {clkPipe[SYNC_STAGES-2:0], serClk};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], serData};
    end
  end

  assign loadS = loadPipe[SYNC_STAGES-1];
  assign clkS  = clkPipe[SYNC_STAGES-1];
  assign dataS = dataPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLoad <= 1'b1;
      prevClk  <= 1'b0;
    end else begin
      prevLoad <= loadS;
      prevClk  <= clkS;
    end
  end

  assign clkRise  = clkS & ~prevClk;
  assign loadRise = loadS & ~prevLoad;

  // Bit counter: cleared while the enable is high, saturates one past a frame
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (loadS) begin
      bitCnt <= '0;
    end else if (clkRise && (bitCnt != OVER_CNT)) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  always_comb begin
    stb.shift  = clkRise & ~loadS;
    stb.bitVal = dataS;
    stb.commit = loadRise & (bitCnt == FULL_CNT);
  end

endmodule

// File: rtl/atten_dp.sv
module atten_dp
  import atten_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int LVL_W     = 8,
  parameter int NUM_TAPS  = 63,
  parameter int CHAN_ADDR = 0,
  localparam int IDX_W    = $clog2(NUM_TAPS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  atten_strobe_t       stb,
  output logic [NUM_TAPS-1:0] tapSel,
  output logic                muted,
  output logic                gndEn,
  output logic [IDX_W-1:0]    level
);

  localparam int FRAME_W = ADDR_W + LVL_W;
  localparam logic [IDX_W-1:0] MUTE_IDX = IDX_W'(NUM_TAPS);

  logic [FRAME_W-1:0]  frameReg;
  logic [ADDR_W-1:0]   frameAddr;
  logic [LVL_W-1:0]    frameLvl;
  logic                addrHit;
  logic                overRange;
  logic [IDX_W-1:0]    nextIdx;
  logic [NUM_TAPS-1:0] nextTap;

  logic [NUM_TAPS-1:0] tapReg;
  logic [IDX_W-1:0]    levelReg;
  logic                muteReg;

  // Frame register, first bit received ends up at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameReg <= '0;
    end else if (stb.shift) begin
      frameReg <= {frameReg[FRAME_W-2:0], stb.bitVal};
    end
  end

  assign frameAddr = frameReg[FRAME_W-1 -: ADDR_W];
  assign frameLvl  = frameReg[LVL_W-1:0];
  assign addrHit   = (frameAddr == ADDR_W'(CHAN_ADDR));
  assign overRange = (32'(frameLvl) >= NUM_TAPS);
  assign nextIdx   = overRange ? MUTE_IDX : IDX_W'(frameLvl);

  // One comparator per tap; the mute index matches none of them
  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tapDec
    assign nextTap[t] = (nextIdx == IDX_W'(t));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapReg   <= '0;
      levelReg <= MUTE_IDX;
      muteReg  <= 1'b1;
    end else if (stb.commit && addrHit) begin
      tapReg   <= nextTap;
      levelReg <= nextIdx;
      muteReg  <= overRange;
    end
  end

  assign tapSel = tapReg;
  assign level  = levelReg;
  assign muted  = muteReg;
  assign gndEn  = muteReg;

endmodule

// File: rtl/serial_atten_ctrl.sv
module serial_atten_ctrl
  import atten_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int LVL_W       = 8,
  parameter int NUM_TAPS    = 63,
  parameter int CHAN_ADDR   = 0,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_TAPS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                serLoadN,
  input  logic                serClk,
  input  logic                serData,
  output logic [NUM_TAPS-1:0] tapSel,
  output logic                muted,
  output logic                gndEn,
  output logic [IDX_W-1:0]    level
);

  atten_strobe_t stb;

  atten_ctl #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_W    (ADDR_W + LVL_W)
  ) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .serLoadN(serLoadN),
    .serClk  (serClk),
    .serData (serData),
    .stb     (stb)
  );

  atten_dp #(
    .ADDR_W   (ADDR_W),
    .LVL_W    (LVL_W),
    .NUM_TAPS (NUM_TAPS),
    .CHAN_ADDR(CHAN_ADDR)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .tapSel(tapSel),
    .muted (muted),
    .gndEn (gndEn),
    .level (level)
  );

endmodule

// File: rtl/atten_ctrl_chk.sv
module atten_ctrl_chk #(
  parameter int NUM_TAPS = 63,
  localparam int IDX_W   = $clog2(NUM_TAPS + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_TAPS-1:0] tapSel,
  input logic                muted,
  input logic                gndEn,
  input logic [IDX_W-1:0]    level,
  input logic                commitStb
);

  // R9: taps are never paralleled
  a_r9_single_tap: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tapSel));

  // R9: grounding switch and any tap never together
  a_r9_gnd_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    gndEn |-> (tapSel == '0));

  // R7: mute reports the mute code
  a_r7_mute_level: assert property (@(posedge clk) disable iff (!rstN)
    muted |-> (level == IDX_W'(NUM_TAPS)));

  // R6: a non-mute setting closes exactly the tap named by level
  a_r6_tap_matches: assert property (@(posedge clk) disable iff (!rstN)
    !muted |-> (tapSel == (NUM_TAPS'(1) << level)));

  // R4: the setting moves only after a commit strobe
  a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(commitStb) |-> ($stable(level) && $stable(tapSel) && $stable(muted)));

endmodule

bind serial_atten_ctrl atten_ctrl_chk #(.NUM_TAPS(NUM_TAPS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tapSel   (tapSel),
  .muted    (muted),
  .gndEn    (gndEn),
  .level    (level),
  .commitStb(stb.commit)
);

// File: tb/test_serial_atten_ctrl.sv
module test_serial_atten_ctrl;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serLoadN = 1'b1;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic [62:0] tapSel;
  logic muted, gndEn;
  logic [5:0] level;

  int checks = 0;
  int errors = 0;
  int expCode = 63;   // 63 stands for mute
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  serial_atten_ctrl i_serial_atten_ctrl (
    .clk(clk), .rstN(rstN), .serLoadN(serLoadN), .serClk(serClk),
    .serData(serData), .tapSel(tapSel), .muted(muted), .gndEn(gndEn),
    .level(level)
  );

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkState(input string req);
    logic [62:0] eTap;
    logic eMute;
    logic [5:0] eLvl;
    eMute = (expCode >= 63);
    eTap  = eMute ? 63'd0 : (63'd1 << expCode);
    eLvl  = eMute ? 6'd63 : 6'(expCode);
    checks++;
    if (tapSel !== eTap || muted !== eMute || gndEn !== eMute || level !== eLvl) begin
      errors++;
      $display("FAIL %s: tap=%h muted=%b gnd=%b level=%0d exp tap=%h muted=%b gnd=%b level=%0d",
               req, tapSel, muted, gndEn, level, eTap, eMute, eMute, eLvl);
    end
    checks++;
    if ($countones(tapSel) > 1) begin
      errors++;
      $display("FAIL R9: %0d taps set, exp at most 1", $countones(tapSel));
    end
  endtask

  task automatic shiftBits(input logic [31:0] word, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      serData = word[i];
      waitCyc(4);
      serClk = 1'b1;
      waitCyc(4);
      serClk = 1'b0;
    end
  endtask

  task automatic sendFrame(input logic [31:0] word, input int nbits);
    serLoadN = 1'b0;
    waitCyc(8);
    shiftBits(word, nbits);
    waitCyc(4);
    serLoadN = 1'b1;
    waitCyc(12);
  endtask

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    checkState("R1 reset mute");

    // R6 / R7: full sweep of the level byte with address 0x00
    for (int c = 0; c < 256; c++) begin
      sendFrame({16'h0, 8'h00, 8'(c)}, 16);
      expCode = (c >= 63) ? 63 : c;
      checkState(c >= 63 ? "R7 mute code" : "R6 tap code");
    end

    // R5: foreign addresses leave the setting alone
    sendFrame(32'h0000_000A, 16);
    expCode = 10;
    checkState("R6 set 10");
    sendFrame(32'h0000_0114, 16);
    checkState("R5 addr 0x01");
    sendFrame(32'h0000_8000, 16);
    checkState("R5 addr 0x80");
    sendFrame(32'h0000_FF3F, 16);
    checkState("R5 addr 0xFF mute code");

    // R3: byte order matters, level 0x25 in the address position is ignored
    sendFrame(32'h0000_2500, 16);
    checkState("R3 swapped bytes");
    sendFrame(32'h0000_0025, 16);
    expCode = 37;
    checkState("R3 msb first 37");

    // R8: short and long frames are dropped
    sendFrame(32'h0000_0005, 15);
    checkState("R8 15 bits");
    sendFrame(32'h0000_0005, 17);
    checkState("R8 17 bits");
    sendFrame(32'h0000_0005, 8);
    checkState("R8 8 bits");

    // R2: clock pulses with the enable high capture nothing
    shiftBits(32'h0000_FFFF, 16);
    waitCyc(12);
    checkState("R2 clocks while idle");
    serLoadN = 1'b0;
    waitCyc(8);
    shiftBits(32'h0000_0007, 16);
    shiftBits(32'h0, 0);
    waitCyc(4);
    serLoadN = 1'b1;
    waitCyc(12);
    expCode = 7;
    checkState("R2 frame after idle clocks");

    // R4: nothing changes before the enable rises
    serLoadN = 1'b0;
    waitCyc(8);
    shiftBits(32'h0000_003E, 16);
    waitCyc(20);
    checkState("R4 before enable rise");
    serLoadN = 1'b1;
    waitCyc(12);
    expCode = 62;
    checkState("R4 after enable rise");

    // R7 from a tap setting straight into mute and back to 0 dB
    sendFrame(32'h0000_0040, 16);
    expCode = 63;
    checkState("R7 code 0x40");
    sendFrame(32'h0000_0000, 16);
    expCode = 0;
    checkState("R6 code 0");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule